// File: doc/BRIEF.md
# Serial Port Host Register Interface

This block is the host-facing register slice of a serial port. A bus master reaches it over an 8-bit data path with a 3-bit byte address. It keeps the channel's configuration bytes (mode, clock select, auxiliary control), an interrupt vector, an interrupt mask and a write-only command port. A status byte is assembled from the serial engine's stub inputs and a sticky warning flag.

The peripheral side runs at half the system clock. The block produces that half-rate phase on `pclk_o` and paces read and acknowledge cycles to it. Writes finish in the cycle they are presented. Configuration that would disturb a running channel is locked while either direction is enabled. During an interrupt-acknowledge cycle the block returns its programmed vector. When the system interrupt controller selects autovectoring, it raises an autovector strobe instead.

Top module: `serial_host_regif`

## Requirements
- R1: Registers are single bytes at these addresses: 0 mode, 1 clock select, 2 auxiliary control, 3 interrupt vector, 4 interrupt mask, 5 status (read-only, bit 7 = warning flag, bits 6:0 = `stat_i`), 6 command (write-only), 7 reserved. A read returns the register contents on `rdata_o` in the cycle where `ack_o` is high. `rdata_o` is zero in every other cycle.
- R2: A read or acknowledge cycle starts in the first cycle where `req_i` is high. Its `ack_o` comes 1 cycle later if `pclk_o` was low in the start cycle, and 2 cycles later if `pclk_o` was high. `pclk_o` resets low and toggles every clock.
- R3: A write cycle (`we_i` high, `iack_i` low) has `ack_o` high in its first cycle. Zero wait states.
- R4: Reading address 6 or address 7 returns 0x00.
- R5: Writes to address 5 or address 7 complete normally and change no register.
- R6: After reset, mode, clock select, auxiliary, mask, warning flag and both channel enables read 0. The vector reads 0x0F.
- R7: While the transmitter or the receiver is enabled, writes to mode and clock select are dropped. A write to the auxiliary register keeps the old bit 7 and updates bits 6:0.
- R8: A dropped mode or clock-select write sets the sticky warning flag. So does an auxiliary write whose bit 7 differs from the stored bit 7. Only command 3 clears the flag.
- R9: In an acknowledge cycle with `autovec_en_i` low, `rdata_o` carries the vector and `autovec_o` stays low. With `autovec_en_i` high, `autovec_o` is high in the ack cycle and `rdata_o` is 0x00.
- R10: Command byte fields: bits 1:0 receiver, bits 3:2 transmitter. In each field, 01 enables, 10 disables, and 00 or 11 has no effect. Bits 6:4 are an action code: 1 resets the receiver, 2 resets the transmitter, 3 clears the warning flag. A reset action clears that direction's enable, overriding its field. It also pulses `rx_rst_o` or `tx_rst_o` for one cycle, in the cycle after the write.
- R11: `irq_o` is high exactly when any bit of (status AND mask) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus cycle request, held until ack |
| we_i | input | 1 | Write when high, read when low |
| iack_i | input | 1 | Interrupt-acknowledge cycle |
| addr_i | input | 3 | Byte register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read / vector data, valid with ack |
| ack_o | output | 1 | Cycle completes at the next edge |
| autovec_o | output | 1 | Autovector strobe during acknowledge |
| pclk_o | output | 1 | Half-rate peripheral phase |
| autovec_en_i | input | 1 | Autovectoring selected (interrupt controller stub) |
| stat_i | input | 7 | Serial engine status bits (stub) |
| mode_o | output | 8 | Mode register contents |
| clksel_o | output | 8 | Clock-select register contents |
| aux_o | output | 8 | Auxiliary register contents |
| tx_en_o | output | 1 | Transmitter enabled |
| rx_en_o | output | 1 | Receiver enabled |
| tx_rst_o | output | 1 | Transmitter reset pulse |
| rx_rst_o | output | 1 | Receiver reset pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that a master holds `req_i`, `we_i`, `iack_i` and `addr_i` steady from the start of a cycle until the edge that follows `ack_o`. They also assume that a master raises no new request before dropping the previous one. The wait-state counter and the protection checks rely on this. The stimulus respects it by driving a full cycle in one task that changes the bus only on falling edges, and by releasing the request after the completion edge. It also varies the idle gaps so that reads start in both half-clock phases.

// File: rtl/serial_regif_pkg.sv
package serial_regif_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] A_MODE   = 3'd0;
  localparam logic [AW-1:0] A_CLKSEL = 3'd1;
  localparam logic [AW-1:0] A_AUX    = 3'd2;
  localparam logic [AW-1:0] A_VEC    = 3'd3;
  localparam logic [AW-1:0] A_MASK   = 3'd4;
  localparam logic [AW-1:0] A_STAT   = 3'd5;
  localparam logic [AW-1:0] A_CMD    = 3'd6;

  typedef enum logic [1:0] {
    DIR_NOP0 = 2'b00,
    DIR_ON   = 2'b01,
    DIR_OFF  = 2'b10,
    DIR_NOP3 = 2'b11
  } dir_cmd_e;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_RX_RST = 3'd1,
    ACT_TX_RST = 3'd2,
    ACT_CLR_WN = 3'd3
  } act_cmd_e;

  typedef struct packed {
    logic       spare;
    logic [2:0] act;
    logic [1:0] tx;
    logic [1:0] rx;
  } cmd_t;
endpackage

// File: rtl/serial_regif_timing.sv
module serial_regif_timing (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rd_i,
  output logic ack_o,
  output logic pclk_o
);
  logic ph_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  // reads wait at least one cycle, then finish on the high peripheral phase
  always_comb ack_o = req_i & (rd_i ? (busy_q & ph_q) : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    busy_q <= 1'b0;
    else if (ack_o)                 busy_q <= 1'b0;
    else if (req_i && rd_i)         busy_q <= 1'b1;
  end

  assign pclk_o = ph_q;

  logic [1:0] wcnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wcnt_q <= '0;
    else if (!req_i || ack_o) wcnt_q <= '0;
    else if (wcnt_q != 2'd3)  wcnt_q <= wcnt_q + 2'd1;
  end

  assert_read_waits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && rd_i) |-> (wcnt_q == 2'd1 || wcnt_q == 2'd2));
  assert_write_no_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !rd_i) |=> (wcnt_q == 2'd0));
endmodule

// File: rtl/serial_regif_cmd.sv
module serial_regif_cmd
  import serial_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_cmd_i,
  input  logic [DW-1:0] wdata_i,
  output logic          tx_en_o,
  output logic          rx_en_o,
  output logic          tx_rst_o,
  output logic          rx_rst_o,
  output logic          clr_warn_o
);
  cmd_t cmd;
  assign cmd = cmd_t'(wdata_i);

  logic rx_kill, tx_kill;
  always_comb begin
    rx_kill    = wr_cmd_i && (cmd.act == ACT_RX_RST);
    tx_kill    = wr_cmd_i && (cmd.act == ACT_TX_RST);
    clr_warn_o = wr_cmd_i && (cmd.act == ACT_CLR_WN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_o  <= 1'b0;
      tx_en_o  <= 1'b0;
      rx_rst_o <= 1'b0;
      tx_rst_o <= 1'b0;
    end else begin
      rx_rst_o <= rx_kill;
      tx_rst_o <= tx_kill;
      if (rx_kill)                                      rx_en_o <= 1'b0;
      else if (wr_cmd_i && cmd.rx == DIR_ON)            rx_en_o <= 1'b1;
      else if (wr_cmd_i && cmd.rx == DIR_OFF)           rx_en_o <= 1'b0;
      if (tx_kill)                                      tx_en_o <= 1'b0;
      else if (wr_cmd_i && cmd.tx == DIR_ON)            tx_en_o <= 1'b1;
      else if (wr_cmd_i && cmd.tx == DIR_OFF)           tx_en_o <= 1'b0;
    end
  end

  assert_tx_reset_disables_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_o |-> !tx_en_o);
  assert_rx_reset_disables_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_o |-> !rx_en_o);
endmodule

// File: rtl/serial_regif_regs.sv
module serial_regif_regs
  import serial_regif_pkg::*;
#(
  parameter logic [DW-1:0] VEC_RST = 8'h0F,
  parameter int unsigned   STAT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              chan_on_i,
  input  logic              clr_warn_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [DW-1:0]     mode_o,
  output logic [DW-1:0]     clksel_o,
  output logic [DW-1:0]     aux_o,
  output logic [DW-1:0]     vec_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              irq_o
);
  localparam int unsigned PAD = DW - 1 - STAT_W;

  logic [DW-1:0] mask_q, stat_byte;
  logic          warn_q;
  logic          wr_mode, wr_clk, wr_aux, wr_vec, wr_mask, blocked;

  always_comb begin
    wr_mode = wr_i && addr_i == A_MODE;
    wr_clk  = wr_i && addr_i == A_CLKSEL;
    wr_aux  = wr_i && addr_i == A_AUX;
    wr_vec  = wr_i && addr_i == A_VEC;
    wr_mask = wr_i && addr_i == A_MASK;
    blocked = chan_on_i && ((wr_mode || wr_clk) ||
                            (wr_aux && (wdata_i[DW-1] != aux_o[DW-1])));
  end

  generate
    if (PAD > 0) begin : g_pad
      assign stat_byte = {warn_q, {PAD{1'b0}}, stat_i};
    end else begin : g_nopad
      assign stat_byte = {warn_q, stat_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= '0;
      clksel_o <= '0;
      aux_o    <= '0;
      vec_o    <= VEC_RST;
      mask_q   <= '0;
      warn_q   <= 1'b0;
    end else begin
      if (wr_mode && !chan_on_i) mode_o   <= wdata_i;
      if (wr_clk  && !chan_on_i) clksel_o <= wdata_i;
      if (wr_aux)  aux_o  <= chan_on_i ? {aux_o[DW-1], wdata_i[DW-2:0]} : wdata_i;
      if (wr_vec)  vec_o  <= wdata_i;
      if (wr_mask) mask_q <= wdata_i;
      if (blocked)         warn_q <= 1'b1;
      else if (clr_warn_i) warn_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:   rd_data_o = mode_o;
      A_CLKSEL: rd_data_o = clksel_o;
      A_AUX:    rd_data_o = aux_o;
      A_VEC:    rd_data_o = vec_o;
      A_MASK:   rd_data_o = mask_q;
      A_STAT:   rd_data_o = stat_byte;
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_o = |(stat_byte & mask_q);

  assert_mode_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mode && chan_on_i) |=> (mode_o == $past(mode_o)));
  assert_clksel_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clk && chan_on_i) |=> (clksel_o == $past(clksel_o)));
  assert_warn_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_q && !clr_warn_i) |=> warn_q);
  assert_irq_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/serial_host_regif.sv
module serial_host_regif
  import serial_regif_pkg::*;
#(
  parameter logic [7:0] VEC_RST = 8'h0F,
  parameter int unsigned STAT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              iack_i,
  input  logic [2:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              ack_o,
  output logic              autovec_o,
  output logic              pclk_o,
  input  logic              autovec_en_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [7:0]        mode_o,
  output logic [7:0]        clksel_o,
  output logic [7:0]        aux_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              tx_rst_o,
  output logic              rx_rst_o,
  output logic              irq_o
);
  logic          rd_type, wr_commit, wr_cmd, clr_warn;
  logic [DW-1:0] vec, rd_data;

  assign rd_type   = ~we_i | iack_i;
  assign wr_commit = ack_o & ~rd_type;
  assign wr_cmd    = wr_commit & (addr_i == A_CMD);

  serial_regif_timing u_timing (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .rd_i   (rd_type),
    .ack_o  (ack_o),
    .pclk_o (pclk_o)
  );

  serial_regif_cmd u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_cmd_i   (wr_cmd),
    .wdata_i    (wdata_i),
    .tx_en_o    (tx_en_o),
    .rx_en_o    (rx_en_o),
    .tx_rst_o   (tx_rst_o),
    .rx_rst_o   (rx_rst_o),
    .clr_warn_o (clr_warn)
  );

  serial_regif_regs #(
    .VEC_RST (VEC_RST),
    .STAT_W  (STAT_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_commit),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .chan_on_i  (tx_en_o | rx_en_o),
    .clr_warn_i (clr_warn),
    .stat_i     (stat_i),
    .mode_o     (mode_o),
    .clksel_o   (clksel_o),
    .aux_o      (aux_o),
    .vec_o      (vec),
    .rd_data_o  (rd_data),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o   = '0;
    autovec_o = 1'b0;
    if (ack_o && iack_i) begin
      if (autovec_en_i) autovec_o = 1'b1;
      else              rdata_o   = vec;
    end else if (ack_o && rd_type) begin
      rdata_o = rd_data;
    end
  end

  assert_autovec_only_in_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    autovec_o |-> (ack_o && iack_i && rdata_o == '0));
  assert_idle_bus_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (rdata_o == '0));
endmodule

// File: tb/serial_host_regif_tb.sv
module serial_host_regif_tb;
  logic       clk = 0, rst_n = 0;
  logic       req = 0, we = 0, iack = 0, av_en = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [6:0] stat = '0;
  logic [7:0] rdata, mode, clksel, aux;
  logic       ack, autovec, pclk, tx_en, rx_en, tx_rst, rx_rst, irq;
  int n_chk = 0, n_bad = 0;
  int seen_ph0 = 0, seen_ph1 = 0;

  always #4 clk = ~clk;

  serial_host_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .iack_i(iack),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .autovec_o(autovec), .pclk_o(pclk), .autovec_en_i(av_en), .stat_i(stat),
    .mode_o(mode), .clksel_o(clksel), .aux_o(aux), .tx_en_o(tx_en),
    .rx_en_o(rx_en), .tx_rst_o(tx_rst), .rx_rst_o(rx_rst), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one full bus cycle; returns at the falling edge after completion
  task automatic bus(input logic w, input logic ia, input logic [2:0] a,
                     input logic [7:0] d, output logic [7:0] rd, output logic av);
    int waits = 0;
    logic ph0;
    @(negedge clk);
    req = 1; we = w; iack = ia; addr = a; wdata = d;
    #1;
    ph0 = pclk;
    while (!ack && waits < 6) begin
      @(negedge clk); #1; waits++;
    end
    rd = rdata; av = autovec;
    if (w && !ia) chk("R3 write waits", waits, 0);
    else begin
      chk("R2 read waits", waits, ph0 ? 2 : 1);
      if (ph0) seen_ph1++; else seen_ph0++;
    end
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0; iack = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] r; logic v;
    bus(1'b1, 1'b0, a, d, r, v);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] r; logic v;
    bus(1'b0, 1'b0, a, 8'h00, r, v);
    chk(tag, r, exp);
  endtask

  // {we, addr, wdata, expected read}
  localparam logic [19:0] VEC [0:15] = '{
    {1'b1, 3'd0, 8'hA5, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'hA5},
    {1'b1, 3'd1, 8'h3C, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h3C},
    {1'b1, 3'd2, 8'h81, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h81},
    {1'b0, 3'd3, 8'h00, 8'h0F},
    {1'b1, 3'd3, 8'h40, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h40},
    {1'b1, 3'd4, 8'h00, 8'h00},
    {1'b1, 3'd7, 8'hFF, 8'h00},
    {1'b0, 3'd7, 8'h00, 8'h00},
    {1'b1, 3'd5, 8'hFF, 8'h00},
    {1'b0, 3'd5, 8'h00, 8'h00},
    {1'b1, 3'd6, 8'hFF, 8'h00},
    {1'b0, 3'd6, 8'h00, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r; logic v;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 mode", mode, 0); chk("R6 aux", aux, 0);
    chk("R6 tx_en", tx_en, 0); chk("R6 irq", irq, 0);
    chk("R1 idle rdata", rdata, 0);
    rst_n = 1;
    rd_chk("R6 vector", 3'd3, 8'h0F);
    rd_chk("R6 status", 3'd5, 8'h00);
    rd_chk("R6 mask", 3'd4, 8'h00);

    // R1 R4 R5 table walk with varying idle gaps
    for (int i = 0; i < 16; i++) begin
      if (i % 3 == 1) @(negedge clk);
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else rd_chk($sformatf("R1/R4/R5 vec%0d", i), VEC[i][18:16], VEC[i][7:0]);
    end
    chk("R5 status write ignored, tx_en", tx_en, 0);
    chk("R2 phase0 starts seen", int'(seen_ph0 > 0), 1);
    chk("R2 phase1 starts seen", int'(seen_ph1 > 0), 1);

    // R10 enable both directions
    wr(3'd6, 8'h05);
    chk("R10 tx_en", tx_en, 1); chk("R10 rx_en", rx_en, 1);
    // R7 R8 locked configuration
    wr(3'd0, 8'h11);
    chk("R7 mode locked", mode, 8'hA5);
    rd_chk("R8 warn set", 3'd5, 8'h80);
    wr(3'd6, 8'h30);
    rd_chk("R8 warn cleared", 3'd5, 8'h00);
    wr(3'd2, 8'h01);
    chk("R7 aux bit7 kept", aux, 8'h81);
    rd_chk("R8 aux warn", 3'd5, 8'h80);
    wr(3'd6, 8'h30);
    wr(3'd2, 8'h82);
    chk("R7 aux same bit7", aux, 8'h82);
    rd_chk("R8 no warn", 3'd5, 8'h00);
    // R10 disable rx only; tx still on keeps lock
    wr(3'd6, 8'h02);
    chk("R10 rx off", rx_en, 0); chk("R10 tx kept", tx_en, 1);
    wr(3'd1, 8'h55);
    chk("R7 clksel locked", clksel, 8'h3C);
    wr(3'd6, 8'h30);
    // R10 transmitter reset overrides enable field
    wr(3'd6, 8'h24);
    chk("R10 tx_rst pulse", tx_rst, 1);
    chk("R10 tx off", tx_en, 0);
    @(negedge clk);
    chk("R10 tx_rst single", tx_rst, 0);
    wr(3'd6, 8'h01);
    wr(3'd6, 8'h10);
    chk("R10 rx_rst pulse", rx_rst, 1); chk("R10 rx off", rx_en, 0);
    wr(3'd1, 8'h55);
    chk("R7 clksel unlocked", clksel, 8'h55);
    rd_chk("R8 warn stays clear", 3'd5, 8'h00);

    // R11 interrupt masking
    stat = 7'h05;
    @(negedge clk);
    chk("R11 masked", irq, 0);
    wr(3'd4, 8'h04);
    chk("R11 enabled", irq, 1);
    wr(3'd4, 8'h02);
    chk("R11 other bit", irq, 0);
    wr(3'd6, 8'h05);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h80);
    chk("R11 warn source", irq, 1);
    wr(3'd6, 8'h30);
    chk("R11 warn cleared", irq, 0);

    // R9 acknowledge cycles
    av_en = 0;
    bus(1'b0, 1'b1, 3'd0, 8'h00, r, v);
    chk("R9 vector data", r, 8'h40); chk("R9 no strobe", v, 0);
    av_en = 1;
    bus(1'b0, 1'b1, 3'd0, 8'h00, r, v);
    chk("R9 autovec strobe", v, 1); chk("R9 autovec data", r, 8'h00);
    chk("R1 idle after", rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule